// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Collector

The collector gathers 64 interrupt request lines into a single IRQ output for a processor. Every line has a four-bit configuration field holding a two-bit priority level, an enable and a software trigger. A line is pending when it is enabled and either its raw input or its software trigger is high. The highest pending level wins. Within a level, the lowest source number wins. The winner's number is shown in a status register, and the vector register returns a table address computed from a programmable base.

Software enters service by writing the vector register. When read-entry mode is set, a read of the vector register enters service instead, as a side effect. Entering service marks the winner's level in an in-service set. A later write to the level-acknowledge register removes that level from the set. With nesting allowed, a new IRQ is raised only for a level strictly above every level in service. A control bit can forbid nesting altogether. Each writable register answers at four word addresses inside its 16-byte slot: plain write, bit set, bit clear and bit toggle. Accesses whose two low address bits are not zero are ignored and read as zero.

Top module: `vic_collector`

## Requirements
- R1: After reset, irq_o is low, and the control, scratch, source-configuration and level-acknowledge registers read zero.
- R2: Address bits 3:2 select how a write combines with a writable register: 0 replaces it, 1 ORs the data in, 2 clears the bits set in the data, and 3 toggles them. The control register at 0x020 keeps only bit 16 (global enable), bit 18 (read-entry mode) and bit 19 (no nesting). All other control bits read zero.
- R3: Source n is configured in the register at 0x060 + 0x10*(n/4), in byte n%4. Within that byte, bits 1:0 are the priority, bit 2 is the enable and bit 3 is the software trigger. Bits 7:4 of each byte read zero.
- R4: A source is pending when its enable is set and either its raw line or its software trigger is high. irq_o rises when control bit 16 is set and a pending source is allowed through. It stays low while bit 16 is clear.
- R5: The highest pending priority wins. Ties go to the lowest source number. Bits 5:0 of the status register at 0x030 give the winner's number.
- R6: The vector register at 0x000 reads base + 4*number. The base register at 0x160 stores bits 31:2, and its bits 1:0 read zero.
- R7: With control bit 18 clear, a write to 0x000 while irq_o is high puts the reported source's level in service. A read of 0x000 does not. A write while irq_o is low does not.
- R8: With control bit 18 set, a read strobe on 0x000 while irq_o is high enters service. A write to 0x000 does not.
- R9: While levels are in service and nesting is allowed, irq_o rises only for a winner whose level is strictly above every in-service level. The reported number and vector stay frozen while no new IRQ is raised.
- R10: With control bit 19 set, irq_o stays low while any level is in service.
- R11: Writing 1 to bit L of 0x010, at any of its four alias addresses, ends service for level L. Reading 0x010 returns the in-service set, with one bit per level.
- R12: 0x040 reads raw lines 31:0 and 0x050 reads raw lines 63:32. Writes to these two registers are ignored.
- R13: The scratch register at 0x1F0 can be read and written, and it has no effect on irq_o or on the reported source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 9 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; only needed for the read-entry side effect |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| raw_i | input | 64 | Raw interrupt request lines |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest state to reach is a nested one: a lower level already in service, a higher request then pre-empting it, and the two levels then acknowledged out of order while lines drop. The vector frozen at entry must not follow the live winner. The stimulus reaches this state in steps. It raises raw lines one at a time, enters service through the vector register and checks the acknowledge register's readback of the in-service set at each step. It then repeats the pattern with nesting forbidden and with read-side-effect entry, and it drops a same-level competitor while service is active to show that the frozen number holds.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_FLIP  = 2'd3
    } alias_op_e;

    localparam int unsigned REG_W = 32;

    // Register slot index = address bits 8:4
    localparam logic [4:0] IDX_VECTOR    = 5'd0;
    localparam logic [4:0] IDX_LVLACK    = 5'd1;
    localparam logic [4:0] IDX_CTRL      = 5'd2;
    localparam logic [4:0] IDX_STATUS    = 5'd3;
    localparam logic [4:0] IDX_RAW_LO    = 5'd4;
    localparam logic [4:0] IDX_RAW_HI    = 5'd5;
    localparam logic [4:0] IDX_SRC_FIRST = 5'd6;
    localparam logic [4:0] IDX_BASE      = 5'd22;
    localparam logic [4:0] IDX_SCRATCH   = 5'd31;

    localparam int unsigned BIT_GLB_EN   = 16;
    localparam int unsigned BIT_RD_ENTER = 18;
    localparam int unsigned BIT_NO_NEST  = 19;

    function automatic logic [REG_W-1:0] apply_alias(
        input alias_op_e        op,
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] val
    );
        case (op)
            OP_WRITE: return val;
            OP_SET:   return cur | val;
            OP_CLEAR: return cur & ~val;
            default:  return cur ^ val;
        endcase
    endfunction

endpackage

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned PRIO_W  = 2,
    parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           found_o,
    output logic [IDX_W-1:0]               idx_o,
    output logic [PRIO_W-1:0]              lvl_o
);
    // Scan from the top index down; ">=" lets a lower index take over a tie.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i] && (!found_o || prio_i[i] >= lvl_o)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                lvl_o   = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/vic_level_gate.sv
module vic_level_gate #(
    parameter int unsigned LEVELS = 4,
    parameter int unsigned PRIO_W = 2
) (
    input  logic [LEVELS-1:0] inserv_i,
    input  logic              found_i,
    input  logic [PRIO_W-1:0] lvl_i,
    input  logic              glb_en_i,
    input  logic              no_nest_i,
    output logic              raise_o
);
    logic blocked;

    always_comb begin
        blocked = 1'b0;
        for (int l = 0; l < LEVELS; l++) begin
            if (inserv_i[l] && (no_nest_i || PRIO_W'(l) >= lvl_i)) begin
                blocked = 1'b1;
            end
        end
        raise_o = glb_en_i && found_i && !blocked;
    end
endmodule

// File: rtl/vic_collector.sv
module vic_collector #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned PRIO_W  = 2,
    parameter int unsigned ADDR_W  = 9
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [vic_pkg::REG_W-1:0] wdata_i,
    input  logic                     wr_i,
    input  logic                     rd_i,
    output logic [vic_pkg::REG_W-1:0] rdata_o,
    input  logic [NUM_SRC-1:0]       raw_i,
    output logic                     irq_o
);
    import vic_pkg::*;

    localparam int unsigned LEVELS   = 1 << PRIO_W;
    localparam int unsigned IDX_W    = $clog2(NUM_SRC);
    localparam int unsigned CFG_W    = PRIO_W + 2;
    localparam int unsigned EN_BIT   = PRIO_W;
    localparam int unsigned SW_BIT   = PRIO_W + 1;
    localparam int unsigned LANE_W   = 8;
    localparam int unsigned SPR      = REG_W / LANE_W;
    localparam int unsigned SRC_REGS = NUM_SRC / SPR;
    localparam int unsigned SLOT_W   = ADDR_W - 4;

    typedef struct packed {
        logic [NUM_SRC-1:0][CFG_W-1:0] cfg;
        logic [LEVELS-1:0]             inserv;
        logic                          glb_en;
        logic                          rd_enter;
        logic                          no_nest;
        logic [REG_W-3:0]              base;
        logic [REG_W-1:0]              scratch;
        logic [IDX_W-1:0]              vec;
        logic                          irq;
    } state_t;

    state_t s_q, s_d;

    logic [SLOT_W-1:0]             slot;
    alias_op_e                     op;
    logic                          aligned;
    logic                          src_hit;
    int                            src_reg;
    logic [REG_W-1:0]              rd_val;
    logic [REG_W-1:0]              new_val;
    logic [2*REG_W-1:0]            raw_pad;
    logic [NUM_SRC-1:0]            pend;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic                          win_found;
    logic [IDX_W-1:0]              win_idx;
    logic [PRIO_W-1:0]             win_lvl;
    logic                          raise;
    logic                          enter;
    logic [LEVELS-1:0]             ack_mask;
    logic                          glb_en_q;
    logic                          no_nest_q;
    logic [LEVELS-1:0]             inserv_q;
    logic [IDX_W-1:0]              vec_q;

    assign glb_en_q  = s_q.glb_en;
    assign no_nest_q = s_q.no_nest;
    assign inserv_q  = s_q.inserv;
    assign vec_q     = s_q.vec;

    assign slot    = addr_i[ADDR_W-1:4];
    assign op      = alias_op_e'(addr_i[3:2]);
    assign aligned = (addr_i[1:0] == 2'b00);
    assign src_reg = int'(slot) - int'(IDX_SRC_FIRST);
    assign src_hit = (src_reg >= 0) && (src_reg < int'(SRC_REGS));
    assign raw_pad = (2*REG_W)'(raw_i);

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            assign pend[g] = s_q.cfg[g][EN_BIT] & (raw_i[g] | s_q.cfg[g][SW_BIT]);
            assign prio[g] = s_q.cfg[g][PRIO_W-1:0];
        end
    endgenerate

    vic_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) u_arb (
        .pend_i  (pend),
        .prio_i  (prio),
        .found_o (win_found),
        .idx_o   (win_idx),
        .lvl_o   (win_lvl)
    );

    vic_level_gate #(
        .LEVELS (LEVELS),
        .PRIO_W (PRIO_W)
    ) u_gate (
        .inserv_i  (inserv_q),
        .found_i   (win_found),
        .lvl_i     (win_lvl),
        .glb_en_i  (glb_en_q),
        .no_nest_i (no_nest_q),
        .raise_o   (raise)
    );

    // Read view of the addressed slot (also the "current" value for aliases)
    always_comb begin
        rd_val = '0;
        case (slot)
            SLOT_W'(IDX_VECTOR):  rd_val = {s_q.base, 2'b00}
                                         + {{(REG_W-IDX_W-2){1'b0}}, s_q.vec, 2'b00};
            SLOT_W'(IDX_LVLACK):  rd_val = REG_W'(s_q.inserv);
            SLOT_W'(IDX_CTRL): begin
                rd_val[BIT_GLB_EN]   = s_q.glb_en;
                rd_val[BIT_RD_ENTER] = s_q.rd_enter;
                rd_val[BIT_NO_NEST]  = s_q.no_nest;
            end
            SLOT_W'(IDX_STATUS):  rd_val = REG_W'(s_q.vec);
            SLOT_W'(IDX_RAW_LO):  rd_val = raw_pad[REG_W-1:0];
            SLOT_W'(IDX_RAW_HI):  rd_val = raw_pad[2*REG_W-1:REG_W];
            SLOT_W'(IDX_BASE):    rd_val = {s_q.base, 2'b00};
            SLOT_W'(IDX_SCRATCH): rd_val = s_q.scratch;
            default: begin
                if (src_hit) begin
                    for (int b = 0; b < int'(SPR); b++) begin
                        rd_val[b*LANE_W +: CFG_W] = s_q.cfg[src_reg*int'(SPR) + b];
                    end
                end
            end
        endcase
    end

    assign rdata_o = aligned ? rd_val : '0;
    assign new_val = apply_alias(op, rd_val, wdata_i);
    assign irq_o   = s_q.irq;

    // Next-state computation
    always_comb begin
        s_d      = s_q;
        ack_mask = '0;
        enter    = s_q.irq && aligned && (slot == SLOT_W'(IDX_VECTOR))
                 && (s_q.rd_enter ? rd_i : wr_i);

        if (wr_i && aligned) begin
            case (slot)
                SLOT_W'(IDX_LVLACK):  ack_mask = wdata_i[LEVELS-1:0];
                SLOT_W'(IDX_CTRL): begin
                    s_d.glb_en   = new_val[BIT_GLB_EN];
                    s_d.rd_enter = new_val[BIT_RD_ENTER];
                    s_d.no_nest  = new_val[BIT_NO_NEST];
                end
                SLOT_W'(IDX_BASE):    s_d.base    = new_val[REG_W-1:2];
                SLOT_W'(IDX_SCRATCH): s_d.scratch = new_val;
                default: begin
                    if (src_hit) begin
                        for (int b = 0; b < int'(SPR); b++) begin
                            s_d.cfg[src_reg*int'(SPR) + b] = new_val[b*LANE_W +: CFG_W];
                        end
                    end
                end
            endcase
        end

        s_d.inserv = s_q.inserv & ~ack_mask;
        if (enter) begin
            s_d.inserv[s_q.cfg[s_q.vec][PRIO_W-1:0]] = 1'b1;
        end

        s_d.irq = raise;
        if (raise) begin
            s_d.vec = win_idx;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/vic_collector_chk.sv
module vic_collector_chk #(
    parameter int unsigned LEVELS = 4,
    parameter int unsigned IDX_W  = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              irq_i,
    input logic              glb_en_i,
    input logic              no_nest_i,
    input logic [LEVELS-1:0] inserv_i,
    input logic [IDX_W-1:0]  vec_i,
    input logic              enter_i,
    input logic [LEVELS-1:0] ack_mask_i
);
    p_glb_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !glb_en_i |=> !irq_i);

    p_no_nest_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (no_nest_i && inserv_i != '0) |=> !irq_i);

    p_vec_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(vec_i) |-> irq_i);

    p_enter_marks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enter_i |=> (inserv_i != '0));

    p_ack_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_mask_i != '0) |=> ((inserv_i & $past(ack_mask_i)) == '0));

    p_enter_needs_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enter_i |-> irq_i);
endmodule

bind vic_collector vic_collector_chk #(
    .LEVELS (LEVELS),
    .IDX_W  (IDX_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_o),
    .glb_en_i   (glb_en_q),
    .no_nest_i  (no_nest_q),
    .inserv_i   (inserv_q),
    .vec_i      (vec_q),
    .enter_i    (enter),
    .ack_mask_i (ack_mask)
);

// File: tb/vic_collector_tb.sv
module vic_collector_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic [63:0] raw = '0;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] got;

    always #5 clk = ~clk;

    vic_collector dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .addr_i  (addr),
        .wdata_i (wdata),
        .wr_i    (wr),
        .rd_i    (rd),
        .rdata_o (rdata),
        .raw_i   (raw),
        .irq_o   (irq)
    );

    // {address, write data, expected read-back at the slot's plain address}
    localparam logic [72:0] VEC_TAB [10] = '{
        {9'h1F0, 32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R13 plain
        {9'h1F4, 32'h0000_F000, 32'hA5A5_FF0F},  // R2 set
        {9'h1F8, 32'h0000_0F0F, 32'hA5A5_F000},  // R2 clear
        {9'h1FC, 32'hFFFF_0000, 32'h5A5A_F000},  // R2 toggle
        {9'h020, 32'hFFFF_FFFF, 32'h000D_0000},  // R2 control mask
        {9'h028, 32'h000D_0000, 32'h0000_0000},  // R2 control clear
        {9'h160, 32'h1000_0003, 32'h1000_0000},  // R6 base low bits
        {9'h06C, 32'hFFFF_FFFF, 32'h0F0F_0F0F},  // R3 toggle source field
        {9'h068, 32'h0F0F_0F0F, 32'h0000_0000},  // R3 clear source field
        {9'h040, 32'hFFFF_FFFF, 32'h0000_0000}   // R12 raw ignores writes
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_strobe(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic peek(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        peek(9'h020, got); check("R1 control", got, 32'h0);
        peek(9'h1F0, got); check("R1 scratch", got, 32'h0);
        peek(9'h060, got); check("R1 source cfg", got, 32'h0);
        peek(9'h010, got); check("R1 in-service", got, 32'h0);

        for (int i = 0; i < 10; i++) begin
            wr_reg(VEC_TAB[i][72:64], VEC_TAB[i][63:32]);
            peek({VEC_TAB[i][72:68], 4'h0}, got);
            check($sformatf("table row %0d (R2/R3/R6/R12/R13)", i), got, VEC_TAB[i][31:0]);
        end

        // R12 raw view
        raw = 64'h1234_5678_9ABC_DEF0;
        peek(9'h040, got); check("R12 raw low", got, 32'h9ABC_DEF0);
        peek(9'h050, got); check("R12 raw high", got, 32'h1234_5678);
        raw = '0;

        wr_reg(9'h160, 32'h0000_1000);
        wr_reg(9'h020, 32'h0001_0000);
        wr_reg(9'h070, 32'h0000_0500);   // src5: en, prio 1
        wr_reg(9'h100, 32'h0000_0707);   // src40/41: en, prio 3
        peek(9'h070, got); check("R3 src5 field", got, 32'h0000_0500);

        raw[5] = 1'b1; settle();
        check("R4 irq raw", {31'b0, irq}, 32'h1);
        peek(9'h030, got); check("R5 status src5", got, 32'd5);
        peek(9'h000, got); check("R6 vector src5", got, 32'h1014);

        raw[40] = 1'b1; raw[41] = 1'b1; settle();
        peek(9'h030, got); check("R5 tie lowest index", got, 32'd40);
        peek(9'h000, got); check("R6 vector src40", got, 32'h10A0);

        rd_strobe(9'h000, got); settle();
        peek(9'h010, got); check("R7 read does not enter", got, 32'h0);
        wr_reg(9'h000, 32'h0); settle();
        peek(9'h010, got); check("R7 write enters level3", got, 32'h8);
        check("R9 irq drops in service", {31'b0, irq}, 32'h0);

        raw[40] = 1'b0; settle();
        peek(9'h030, got); check("R9 status frozen", got, 32'd40);

        wr_reg(9'h010, 32'h8); settle();
        peek(9'h010, got); check("R11 ack clears", got, 32'h0);
        check("R11 irq returns", {31'b0, irq}, 32'h1);
        peek(9'h030, got); check("R5 next winner", got, 32'd41);

        // Nesting
        raw = '0; raw[5] = 1'b1; settle();
        wr_reg(9'h000, 32'h0); settle();
        peek(9'h010, got); check("R7 level1 in service", got, 32'h2);
        raw[41] = 1'b1; settle();
        check("R9 higher preempts", {31'b0, irq}, 32'h1);
        peek(9'h030, got); check("R9 preempt status", got, 32'd41);
        wr_reg(9'h000, 32'h0); settle();
        peek(9'h010, got); check("R9 nested set", got, 32'hA);
        raw[41] = 1'b0;
        wr_reg(9'h01C, 32'h8); settle();
        peek(9'h010, got); check("R11 toggle alias acks", got, 32'h2);
        check("R9 equal level blocked", {31'b0, irq}, 32'h0);
        wr_reg(9'h010, 32'h2); settle();
        check("R9 irq after ack", {31'b0, irq}, 32'h1);
        peek(9'h030, got); check("R9 status src5", got, 32'd5);

        // No nesting
        wr_reg(9'h024, 32'h0008_0000);
        wr_reg(9'h000, 32'h0); settle();
        raw[41] = 1'b1; settle();
        check("R10 no nest irq low", {31'b0, irq}, 32'h0);
        peek(9'h030, got); check("R10 status held", got, 32'd5);
        wr_reg(9'h010, 32'h2); settle();
        check("R10 irq after ack", {31'b0, irq}, 32'h1);
        peek(9'h030, got); check("R10 status src41", got, 32'd41);

        // Read-entry mode
        wr_reg(9'h024, 32'h0004_0000);
        wr_reg(9'h000, 32'h0); settle();
        peek(9'h010, got); check("R8 write ignored", got, 32'h0);
        rd_strobe(9'h000, got);
        check("R8 vector read value", got, 32'h10A4);
        settle();
        peek(9'h010, got); check("R8 read enters", got, 32'h8);

        // Software trigger, scratch, global enable
        wr_reg(9'h010, 32'hF);
        raw = '0;
        wr_reg(9'h028, 32'h000C_0000);
        wr_reg(9'h080, 32'h0000_0E00);   // src9: sw, en, prio 2
        settle();
        check("R4 software irq", {31'b0, irq}, 32'h1);
        peek(9'h030, got); check("R4 software status", got, 32'd9);
        wr_reg(9'h1F0, 32'hDEAD_BEEF); settle();
        check("R13 irq unchanged", {31'b0, irq}, 32'h1);
        peek(9'h030, got); check("R13 status unchanged", got, 32'd9);
        peek(9'h1F0, got); check("R13 scratch", got, 32'hDEAD_BEEF);
        wr_reg(9'h028, 32'h0001_0000); settle();
        check("R4 global disable", {31'b0, irq}, 32'h0);
        wr_reg(9'h000, 32'h0); settle();
        peek(9'h010, got); check("R7 no entry without irq", got, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule